// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Hours

This block keeps wall-clock time and date in packed BCD, from seconds up to a two-digit year standing for 2000 to 2099. A fast enable pulse `osc_tick` is divided internally by `TICKS_PER_SEC`. Each time the divider wraps, the calendar advances by one second. The hours field holds either a 24-hour count or a 12-hour count with a mode flag and a PM flag. Software switches between the two encodings by writing the hours register.

A bus front end reaches the eight byte registers through a single address port. Writes take effect on the next clock edge. Reads are combinational. A stop bit in the control register freezes the divider and every field. Any register write restarts the sub-second phase, so the first second after a load is a full second long. The `sec_strobe` output is a one-cycle pulse that marks each advance, for use by alarm comparison logic placed next to this block.

Top module: `bcd_calendar`

## Requirements
- R1: Register addresses are 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month, 6 year and 7 control. After reset the time reads 00:00:00 in 24-hour mode, weekday 01, day 01, month 01, year 00, and control reads 0x00.
- R2: After every `TICKS_PER_SEC` consecutive `osc_tick` cycles, seconds advance by one. `sec_strobe` is high for exactly one cycle, and in that cycle the new time is already readable. With no ticks, nothing changes.
- R3: Seconds and minutes count 00 to 59 in BCD, with a carry from the low digit into the tens digit. A wrap to 00 advances the next field.
- R4: With hours bit 6 clear, hours count 00 to 23. A wrap from 23 to 00 advances the weekday and the day of month.
- R5: Weekday counts 1 to 7 and then returns to 1. Month counts 1 to 12 and then returns to 1, which advances the year. Year counts 00 to 99 and then returns to 00 without touching any other field.
- R6: With hours bit 6 set, bits 4:0 hold 1 to 12 in BCD and bit 5 is PM. Hour 11 steps to 12 and toggles PM. Hour 12 steps to 1 and keeps PM. Only the step from 11 PM to 12 AM advances the day. Bit 6 never changes on an advance.
- R7: The day of month wraps to 01 after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11. In month 2 it wraps after 29 when the year value is divisible by 4, and after 28 otherwise.
- R8: Control bit 7 set stops counting: no field changes and `sec_strobe` stays low. Control bits 6:0 read as 0.
- R9: A register write in a cycle takes the place of any advance in that cycle and clears the sub-second phase. The next advance then needs `TICKS_PER_SEC` further ticks.
- R10: A field written with an out-of-range value keeps it until that field is next stepped. If the value is at or above the field's maximum, the step goes to the field's minimum and carries. If the low digit is 9 or more, the step goes to the next tens digit with a low digit of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Sub-second enable from the oscillator domain, one cycle per oscillator period |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| sec_strobe | output | 1 | One-cycle pulse when the calendar has advanced |

## Verification
The assertions assume that `reg_we` is meaningful in every cycle out of reset. They also assume that once a stop bit has been written, no write arrives to disturb the frozen fields. The value checks assume that `osc_tick` is the only source of advances. The stimulus keeps `osc_tick` low whenever it reads or writes registers, so every advance happens at a tick edge the bench has counted. Out-of-range field values are produced only on purpose, to exercise the step rules for invalid values.

// File: rtl/cal_pkg.sv
package cal_pkg;

    localparam int FIELD_W   = 8;
    localparam int ADDR_W    = 3;
    localparam int HR_MODE_B = 6;
    localparam int HR_PM_B   = 5;
    localparam int STOP_B    = 7;

    typedef logic [FIELD_W-1:0] bcd8_t;

    typedef enum logic [ADDR_W-1:0] {
        AD_SEC   = 3'd0,
        AD_MIN   = 3'd1,
        AD_HOUR  = 3'd2,
        AD_WDAY  = 3'd3,
        AD_DATE  = 3'd4,
        AD_MONTH = 3'd5,
        AD_YEAR  = 3'd6,
        AD_CTRL  = 3'd7
    } cal_addr_e;

    typedef struct packed {
        bcd8_t year;
        bcd8_t month;
        bcd8_t date;
        bcd8_t wday;
        bcd8_t hour;
        bcd8_t min;
        bcd8_t sec;
    } cal_time_t;

    typedef struct packed {
        bcd8_t val;
        logic  carry;
    } step_t;

    // Generic BCD field step between lo and hi, tolerant of bad digits.
    function automatic step_t bcd_step(bcd8_t v, bcd8_t lo, bcd8_t hi);
        step_t r;
        if (v >= hi) begin
            r.val   = lo;
            r.carry = 1'b1;
        end else if (v[3:0] >= 4'd9) begin
            r.val   = {v[7:4] + 4'd1, 4'd0};
            r.carry = 1'b0;
        end else begin
            r.val   = {v[7:4], v[3:0] + 4'd1};
            r.carry = 1'b0;
        end
        return r;
    endfunction

    // Year value mod 4 equals (2*tens + ones) mod 4.
    function automatic logic year_is_leap(bcd8_t y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return ((s & 5'd3) == 5'd0);
    endfunction

    function automatic bcd8_t month_last_day(bcd8_t mon, bcd8_t yr);
        bcd8_t d;
        case (mon)
            8'h02:                      d = year_is_leap(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

    // Hours step in either encoding; carry means a new day begins.
    function automatic step_t hour_step(bcd8_t h);
        step_t      r;
        logic [4:0] hv;
        logic       pm;
        hv = h[4:0];
        pm = h[HR_PM_B];
        if (h[HR_MODE_B]) begin
            r.carry = 1'b0;
            if (hv == 5'h11) begin
                r.val   = {h[7:6], ~pm, 5'h12};
                r.carry = pm;
            end else if (hv >= 5'h12) begin
                r.val = {h[7:6], pm, 5'h01};
            end else if (hv[3:0] >= 4'd9) begin
                r.val = {h[7:5], 1'b1, 4'h0};
            end else begin
                r.val = {h[7:5], hv[4], hv[3:0] + 4'd1};
            end
        end else begin
            r = bcd_step(h, 8'h00, 8'h23);
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hold,
    input  logic clear,
    output logic sec_pulse
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] phase_q;

    assign sec_pulse = tick && !hold && !clear && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            phase_q <= '0;
        end else if (tick && !hold) begin
            phase_q <= (phase_q == LAST) ? '0 : phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/cal_advance.sv
module cal_advance
    import cal_pkg::*;
(
    input  cal_time_t cur,
    output cal_time_t nxt
);
    step_t s_st, m_st, h_st, w_st, d_st, mo_st, y_st;

    always_comb begin
        nxt   = cur;
        s_st  = bcd_step(cur.sec, 8'h00, 8'h59);
        m_st  = bcd_step(cur.min, 8'h00, 8'h59);
        h_st  = hour_step(cur.hour);
        w_st  = bcd_step(cur.wday, 8'h01, 8'h07);
        d_st  = bcd_step(cur.date, 8'h01, month_last_day(cur.month, cur.year));
        mo_st = bcd_step(cur.month, 8'h01, 8'h12);
        y_st  = bcd_step(cur.year, 8'h00, 8'h99);

        nxt.sec = s_st.val;
        if (s_st.carry) begin
            nxt.min = m_st.val;
            if (m_st.carry) begin
                nxt.hour = h_st.val;
                if (h_st.carry) begin
                    nxt.wday = w_st.val;
                    nxt.date = d_st.val;
                    if (d_st.carry) begin
                        nxt.month = mo_st.val;
                        if (mo_st.carry) begin
                            nxt.year = y_st.val;
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       osc_tick,
    input  logic       reg_we,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sec_strobe
);
    localparam cal_time_t RESET_TIME = '{
        year: 8'h00, month: 8'h01, date: 8'h01, wday: 8'h01,
        hour: 8'h00, min: 8'h00, sec: 8'h00
    };

    cal_time_t time_q, time_nxt;
    logic      stop_q;
    logic      strobe_q;
    logic      adv_pulse;

    cal_prescaler #(.TICKS(TICKS_PER_SEC)) u_div (
        .clk      (clk),
        .rst      (rst),
        .tick     (osc_tick),
        .hold     (stop_q),
        .clear    (reg_we),
        .sec_pulse(adv_pulse)
    );

    cal_advance u_adv (
        .cur(time_q),
        .nxt(time_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q   <= RESET_TIME;
            stop_q   <= 1'b0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= adv_pulse;
            if (reg_we) begin
                case (cal_addr_e'(reg_addr))
                    AD_SEC:   time_q.sec   <= reg_wdata;
                    AD_MIN:   time_q.min   <= reg_wdata;
                    AD_HOUR:  time_q.hour  <= reg_wdata;
                    AD_WDAY:  time_q.wday  <= reg_wdata;
                    AD_DATE:  time_q.date  <= reg_wdata;
                    AD_MONTH: time_q.month <= reg_wdata;
                    AD_YEAR:  time_q.year  <= reg_wdata;
                    default:  stop_q       <= reg_wdata[STOP_B];
                endcase
            end else if (adv_pulse) begin
                time_q <= time_nxt;
            end
        end
    end

    always_comb begin
        case (cal_addr_e'(reg_addr))
            AD_SEC:   reg_rdata = time_q.sec;
            AD_MIN:   reg_rdata = time_q.min;
            AD_HOUR:  reg_rdata = time_q.hour;
            AD_WDAY:  reg_rdata = time_q.wday;
            AD_DATE:  reg_rdata = time_q.date;
            AD_MONTH: reg_rdata = time_q.month;
            AD_YEAR:  reg_rdata = time_q.year;
            default:  reg_rdata = {stop_q, 7'b0};
        endcase
    end

    assign sec_strobe = strobe_q;

    // R8
    stop_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !reg_we) |=> $stable(time_q));

    // R8
    stop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (stop_q && !reg_we) |=> !sec_strobe);

    // R9
    write_no_step_chk: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !sec_strobe);

    // R3
    sec_valid_chk: assert property (@(posedge clk) disable iff (rst)
        sec_strobe |-> (time_q.sec[3:0] <= 4'd9 && time_q.sec <= 8'h59));

    // R6
    mode_keep_chk: assert property (@(posedge clk) disable iff (rst)
        sec_strobe |-> (time_q.hour[HR_MODE_B] == $past(time_q.hour[HR_MODE_B])));

endmodule

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
    import cal_pkg::*;

    localparam int TK = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       osc_tick = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] drv_addr = 3'd0;
    logic [2:0] mon_addr = 3'd0;
    logic       mon_on = 1'b0;
    logic [2:0] reg_addr;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sec_strobe;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [2:0] a;
        logic [7:0] v;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    assign reg_addr = mon_on ? mon_addr : drv_addr;

    bcd_calendar #(.TICKS_PER_SEC(TK)) uut (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sec_strobe(sec_strobe)
    );

    always #2 clk = ~clk;

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    // Monitor: pops expected register values and compares them at the port.
    initial begin : monitor
        forever begin
            wait (sb_q.size() > 0);
            @(negedge clk);
            mon_addr = sb_q[0].a;
            mon_on   = 1'b1;
            #1;
            check(sb_q[0].tag, reg_rdata, sb_q[0].v);
            mon_on = 1'b0;
            void'(sb_q.pop_front());
        end
    end

    task automatic push(logic [2:0] a, logic [7:0] v, string tag);
        exp_t e;
        e.a = a; e.v = v; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic drain();
        wait (sb_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic expect_time(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                               logic [7:0] w, logic [7:0] d, logic [7:0] mo,
                               logic [7:0] y, string tag);
        push(3'd0, s, {tag, " sec"});
        push(3'd1, m, {tag, " min"});
        push(3'd2, h, {tag, " hour"});
        push(3'd3, w, {tag, " wday"});
        push(3'd4, d, {tag, " date"});
        push(3'd5, mo, {tag, " month"});
        push(3'd6, y, {tag, " year"});
        drain();
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        drv_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic set_time(logic [7:0] s, logic [7:0] m, logic [7:0] h,
                            logic [7:0] w, logic [7:0] d, logic [7:0] mo,
                            logic [7:0] y);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, w);
        wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
    endtask

    // Drives n consecutive tick cycles; counts strobes and the last index seen.
    task automatic run_ticks(int n, output int nstrobe, output int last_idx);
        nstrobe  = 0;
        last_idx = -1;
        @(negedge clk);
        osc_tick = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sec_strobe) begin
                nstrobe++;
                last_idx = i;
            end
            if (i == n - 1) osc_tick = 1'b0;
        end
    endtask

    task automatic one_second(string tag);
        int ns, li;
        run_ticks(TK, ns, li);
        check({tag, " strobe count"}, 8'(ns), 8'd1);
        check({tag, " strobe cycle"}, 8'(li), 8'(TK - 1));
    endtask

    initial begin : driver
        int ns, li;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values and control
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R1 reset");
        push(3'd7, 8'h00, "R1 ctrl reset");
        drain();

        // R2 idle cycles change nothing, then one second advances
        repeat (10) @(negedge clk);
        check("R2 idle strobe", {7'b0, sec_strobe}, 8'h00);
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 idle");
        one_second("R2");
        expect_time(8'h01, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R2 step");

        // R3 digit carry and minute carry
        set_time(8'h59, 8'h09, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21);
        one_second("R3");
        expect_time(8'h00, 8'h10, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21, "R3 carry");

        // R4 R5 full wrap on the last second of 2099
        set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        one_second("R4");
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, "R4 R5 wrap");

        // R6 12-hour transitions
        set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h24);
        one_second("R6 am");
        expect_time(8'h00, 8'h00, 8'h72, 8'h03, 8'h15, 8'h06, 8'h24, "R6 11am to 12pm");
        set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h24);
        one_second("R6 pm");
        expect_time(8'h00, 8'h00, 8'h52, 8'h04, 8'h16, 8'h06, 8'h24, "R6 11pm to 12am");
        set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h24);
        one_second("R6 noon");
        expect_time(8'h00, 8'h00, 8'h61, 8'h03, 8'h15, 8'h06, 8'h24, "R6 12pm to 1pm");
        set_time(8'h59, 8'h59, 8'h49, 8'h03, 8'h15, 8'h06, 8'h24);
        one_second("R6 nine");
        expect_time(8'h00, 8'h00, 8'h50, 8'h03, 8'h15, 8'h06, 8'h24, "R6 9am to 10am");

        // R7 month lengths and leap years
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h23);
        one_second("R7 feb");
        expect_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h23, "R7 feb common");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h24);
        one_second("R7 leap");
        expect_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h24, "R7 feb leap 28");
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h29, 8'h02, 8'h24);
        one_second("R7 leap end");
        expect_time(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h24, "R7 feb leap 29");
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h30);
        one_second("R7 apr");
        expect_time(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h30, "R7 apr 30");
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h01, 8'h30);
        one_second("R7 jan");
        expect_time(8'h00, 8'h00, 8'h00, 8'h06, 8'h31, 8'h01, 8'h30, "R7 jan 30");

        // R8 stop bit freezes everything
        set_time(8'h20, 8'h15, 8'h10, 8'h04, 8'h12, 8'h08, 8'h45);
        wr(3'd7, 8'hFF);
        push(3'd7, 8'h80, "R8 ctrl stopped");
        drain();
        run_ticks(3 * TK, ns, li);
        check("R8 no strobe when stopped", 8'(ns), 8'd0);
        expect_time(8'h20, 8'h15, 8'h10, 8'h04, 8'h12, 8'h08, 8'h45, "R8 frozen");
        wr(3'd7, 8'h7F);
        push(3'd7, 8'h00, "R8 ctrl running");
        drain();
        one_second("R8 resume");
        expect_time(8'h21, 8'h15, 8'h10, 8'h04, 8'h12, 8'h08, 8'h45, "R8 resumed");

        // R9 a write restarts the sub-second phase
        wr(3'd0, 8'h10);
        run_ticks(TK - 1, ns, li);
        check("R9 partial second", 8'(ns), 8'd0);
        wr(3'd0, 8'h20);
        run_ticks(TK - 1, ns, li);
        check("R9 phase cleared", 8'(ns), 8'd0);
        push(3'd0, 8'h20, "R9 no early step");
        drain();
        run_ticks(1, ns, li);
        check("R9 full second", 8'(ns), 8'd1);
        push(3'd0, 8'h21, "R9 stepped");
        drain();

        // R10 out-of-range values
        set_time(8'h5C, 8'h10, 8'h08, 8'h01, 8'h05, 8'h05, 8'h05);
        push(3'd0, 8'h5C, "R10 held as written");
        drain();
        one_second("R10 over");
        expect_time(8'h00, 8'h11, 8'h08, 8'h01, 8'h05, 8'h05, 8'h05, "R10 over max");
        wr(3'd0, 8'h3A);
        one_second("R10 digit");
        expect_time(8'h40, 8'h11, 8'h08, 8'h01, 8'h05, 8'h05, 8'h05, "R10 bad digit");

        summary();
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

endmodule